// File: doc/BRIEF.md
# Time-Field Decimal Digit Splitter

This block turns three binary time fields (seconds, minutes and hours, each 0 to 99) into pairs of decimal digits for six display positions. Each field goes through its own splitter. The splitter finds the tens digit by multiplying by the constant 103 and shifting right by 10 bits, which stands in for a divide by ten. It then finds the ones digit by subtracting ten times the tens digit from the input.

The three fields enter together as one beat on a valid/ready input. The digits leave together as one beat on a valid/ready output after a single register stage. The input is accepted when the stage is empty, or when the stage is full and the downstream side takes its word in the same cycle. While the output is valid and not taken, the stage holds its word unchanged and refuses new input. A held word is never replaced or dropped.

Top module: `dsplit_time_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For each field value v from 0 to 99, the tens digit of that field equals v / 10 (integer division). It sits in the upper nibble of the field's byte.
- R3: For each field value v from 0 to 99, the ones digit of that field equals v mod 10. It sits in the lower nibble of the field's byte.
- R4: Every digit presented with `out_valid` high lies in 0 to 9.
- R5: Field k occupies `in_fields[7k+6:7k]` and its digit pair occupies `out_digits[8k+7:8k]`. Field 0 is seconds, field 1 is minutes and field 2 is hours. The fields do not affect each other.
- R6: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its digits appear with `out_valid` high from the next cycle on.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_digits` stays stable on the next cycle.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: Every accepted beat is delivered exactly once, in order. None is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_fields | input | 21 | Three 7-bit binary fields: seconds, minutes, hours (low to high) |
| out_valid | output | 1 | Output digit beat present |
| out_ready | input | 1 | Downstream takes the output beat this cycle |
| out_digits | output | 24 | Three bytes, each {tens, ones} in BCD, in the same field order |

## Verification
The hardest case to reach from the ports is a cycle where the stage is full, `out_ready` is low and a new beat is waiting at the input. In that cycle the held digits must stay frozen and the waiting beat must not be accepted. Another hard case is a cycle where a beat is taken and a new one is loaded on the same edge. The bench first sweeps all 100 values through every field with the output always ready, giving each field a different offset so that misplaced fields show up. It then runs a long phase in which `in_valid` and `out_ready` are toggled pseudo-randomly, so that stalls, stalls with a pending input, and take-and-load edges all occur many times.

// File: rtl/dsplit_pkg.sv
package dsplit_pkg;
  localparam int DIG_W = 4;

  typedef struct packed {
    logic [DIG_W-1:0] tens;
    logic [DIG_W-1:0] ones;
  } digit_pair_t;
endpackage

// File: rtl/dsplit_div10.sv
module dsplit_div10 #(
  parameter int IN_W  = 7,
  parameter int MUL   = 103,
  parameter int SHIFT = 10,
  parameter int Q_W   = 4
) (
  input  logic [IN_W-1:0] value,
  output logic [Q_W-1:0]  quot
);
  localparam int MUL_W  = $clog2(MUL + 1);
  localparam int PROD_W = IN_W + MUL_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = {{MUL_W{1'b0}}, value} * PROD_W'(MUL);
    quot = Q_W'(prod >> SHIFT);
  end
endmodule

// File: rtl/dsplit_digit_pair.sv
module dsplit_digit_pair
  import dsplit_pkg::*;
#(
  parameter int IN_W  = 7,
  parameter int MUL   = 103,
  parameter int SHIFT = 10
) (
  input  logic [IN_W-1:0] value,
  output digit_pair_t     digits
);
  logic [DIG_W-1:0] tens;
  logic [IN_W-1:0]  tens_ext;
  logic [IN_W-1:0]  tens_x10;
  logic [IN_W-1:0]  rem;

  dsplit_div10 #(
    .IN_W (IN_W),
    .MUL  (MUL),
    .SHIFT(SHIFT),
    .Q_W  (DIG_W)
  ) u_div (
    .value(value),
    .quot (tens)
  );

  always_comb begin
    tens_ext    = IN_W'(tens);
    tens_x10    = (tens_ext << 3) + (tens_ext << 1);
    rem         = value - tens_x10;
    digits.tens = tens;
    digits.ones = DIG_W'(rem);
  end
endmodule

// File: rtl/dsplit_out_stage.sv
module dsplit_out_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic held_q;
  logic [W-1:0] data_q;
  logic load_fire;

  always_comb begin
    load_ready = !held_q || out_ready;
    load_fire  = load_valid && load_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (load_fire) begin
      held_q <= 1'b1;
    end else if (out_ready) begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_fire) data_q <= load_data;
  end

  assign out_valid = held_q;
  assign out_data  = data_q;
endmodule

// File: rtl/dsplit_time_top.sv
module dsplit_time_top
  import dsplit_pkg::*;
#(
  parameter int FIELDS = 3,
  parameter int IN_W   = 7,
  parameter int MUL    = 103,
  parameter int SHIFT  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [FIELDS*IN_W-1:0]      in_fields,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [FIELDS*2*DIG_W-1:0]   out_digits
);
  localparam int PAIR_W = 2 * DIG_W;
  localparam int OUT_W  = FIELDS * PAIR_W;

  logic [OUT_W-1:0] split_word;

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    digit_pair_t pair;
    dsplit_digit_pair #(
      .IN_W (IN_W),
      .MUL  (MUL),
      .SHIFT(SHIFT)
    ) u_pair (
      .value (in_fields[k*IN_W +: IN_W]),
      .digits(pair)
    );
    assign split_word[k*PAIR_W +: PAIR_W] = pair;
  end

  dsplit_out_stage #(.W(OUT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_valid(in_valid),
    .load_ready(in_ready),
    .load_data (split_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_digits)
  );
endmodule

// File: rtl/dsplit_time_top_chk.sv
module dsplit_time_top_chk #(
  parameter int FIELDS = 3,
  parameter int IN_W   = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [FIELDS*IN_W-1:0] in_fields,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [FIELDS*8-1:0]    out_digits
);
  assert_load_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digits)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_empty_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  for (genvar k = 0; k < FIELDS; k++) begin : g_chk
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_digits[k*8+4 +: 4] <= 4'd9 && out_digits[k*8 +: 4] <= 4'd9));

    // R2 and R3 together: the digits rebuild the accepted value
    assert_digits_rebuild_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_fields[k*IN_W +: IN_W] < IN_W'(100)) |=>
      (32'(out_digits[k*8+4 +: 4]) * 10 + 32'(out_digits[k*8 +: 4])
        == 32'($past(in_fields[k*IN_W +: IN_W]))));
  end
endmodule

bind dsplit_time_top dsplit_time_top_chk #(.FIELDS(FIELDS), .IN_W(IN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_fields (in_fields),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_digits(out_digits)
);

// File: tb/dsplit_time_top_bench.sv
`timescale 1ns/1ps
module dsplit_time_top_bench;
  localparam int FIELDS = 3;
  localparam int IN_W   = 7;
  localparam int OUT_W  = FIELDS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FIELDS*IN_W-1:0] in_fields = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [OUT_W-1:0] out_digits;

  int n_cmp = 0;
  int n_bad = 0;
  int n_in = 0;
  int n_out = 0;
  bit done = 1'b0;
  logic [OUT_W-1:0] expq[$];
  bit stall_prev = 1'b0;
  logic [OUT_W-1:0] stall_word;

  always #4 clk = ~clk;

  dsplit_time_top u_dsplit_time_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fields(in_fields), .out_valid(out_valid), .out_ready(out_ready),
    .out_digits(out_digits)
  );

  function automatic logic [OUT_W-1:0] ref_word(input logic [FIELDS*IN_W-1:0] f);
    logic [OUT_W-1:0] w;
    for (int k = 0; k < FIELDS; k++) begin
      int v;
      v = int'(f[k*IN_W +: IN_W]);
      w[k*8+4 +: 4] = 4'(v / 10);
      w[k*8 +: 4]   = 4'(v % 10);
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock of the reference model: check outputs, drive, record handshakes
  task automatic step(input bit iv, input logic [FIELDS*IN_W-1:0] f, input bit ordy);
    @(negedge clk);
    check(out_valid == (expq.size() != 0), "R6 out_valid", int'(out_valid), int'(expq.size() != 0));
    if (stall_prev) begin
      check(out_valid == 1'b1, "R7 held valid", int'(out_valid), 1);
      check(out_digits == stall_word, "R7 held digits", int'(out_digits), int'(stall_word));
    end
    if (out_valid && expq.size() != 0) begin
      for (int k = 0; k < FIELDS; k++) begin
        check(out_digits[k*8+4 +: 4] == expq[0][k*8+4 +: 4], "R2/R5 tens",
              int'(out_digits[k*8+4 +: 4]), int'(expq[0][k*8+4 +: 4]));
        check(out_digits[k*8 +: 4] == expq[0][k*8 +: 4], "R3/R5 ones",
              int'(out_digits[k*8 +: 4]), int'(expq[0][k*8 +: 4]));
        check(out_digits[k*8+4 +: 4] <= 4'd9 && out_digits[k*8 +: 4] <= 4'd9, "R4 range",
              int'(out_digits[k*8 +: 8]), 99);
      end
    end
    in_valid  = iv;
    in_fields = f;
    out_ready = ordy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R8 in_ready", int'(in_ready),
          int'(!out_valid || out_ready));
    stall_prev = out_valid && !out_ready;
    stall_word = out_digits;
    if (out_valid && out_ready && expq.size() != 0) begin
      void'(expq.pop_front());
      n_out++;
    end
    if (in_valid && in_ready) begin
      expq.push_back(ref_word(in_fields));
      n_in++;
    end
  endtask

  function automatic logic [FIELDS*IN_W-1:0] pack3(input int s, input int m, input int h);
    return {IN_W'(h), IN_W'(m), IN_W'(s)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    // exhaustive sweep, each field offset differently
    for (int v = 0; v < 100; v++)
      step(1'b1, pack3(v, (v + 37) % 100, (v + 71) % 100), 1'b1);
    step(1'b0, '0, 1'b1);
    // corner values, with stalls
    step(1'b1, pack3(99, 0, 9), 1'b0);
    step(1'b1, pack3(10, 90, 59), 1'b0);
    step(1'b1, pack3(10, 90, 59), 1'b1);
    step(1'b0, '0, 1'b1);
    // random valid / ready traffic
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, pack3($urandom_range(99), $urandom_range(99), $urandom_range(99)),
           ($urandom % 3) != 0);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    check(n_in == n_out && expq.size() == 0, "R9 beats in/out", n_out, n_in);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule